// File: doc/BRIEF.md
# Capture/Compare Timebase Counter with Coherent Byte Reads

This block is the shared timebase for a set of capture/compare channels. A 16-bit up-counter runs freely and advances on the enable pulses of a programmable prescaler. A 2-bit select field divides the input clock by 1, 16, 256 or 4096. The live count goes straight to the channels on a wide output.

Software reads the count over a byte-wide register port. The low byte must be read first. That read captures the full count into a hold register and sets a lock flag. The following high-byte read returns the upper half of the captured value and clears the flag, so the two bytes always belong to the same count. The lock affects only what reads return: the live counter keeps running. Writing the select register restarts the prescaler from zero.

Register addresses on `busAddr`: 0 is the count low byte (read), 1 is the count high byte (read), 2 is the clock select (write-only; the select code sits in bits 1:0), and 3 is unused.

Top module: `cap_timebase`

## Requirements
- R1: While reset is asserted, `count` is 0, the select code is 00 and the lock is clear. Reads at addresses 0 and 1 return 0x00.
- R2: With select code 00, `count` increments by one on every clock edge, except the edge on which the select register is written.
- R3: With select code 01, 10 or 11, `count` increments once every 16, 256 or 4096 clock edges respectively.
- R4: A write to address 2 takes bits 1:0 as the new code, restarts the prescaler and suppresses the increment on that edge. The first increment after the write happens exactly 2^(4×code) edges after the write edge.
- R5: The counter wraps from 0xFFFF to 0x0000.
- R6: A read at address 0 returns the low byte of the live count. On that edge it captures the whole count into the hold register and sets the lock.
- R7: A read at address 1 while locked returns bits 15:8 of the held value and clears the lock.
- R8: While locked, the live `count` keeps advancing at the selected rate.
- R9: A read at address 0 while already locked captures a new value that replaces the old one.
- R10: A read at address 1 while unlocked returns bits 15:8 of the live count.
- R11: Reads at address 2 or 3 return 0x00. Writes to addresses 0, 1 and 3 have no effect on the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 2 | Register address |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 8 | Write data |
| busRdEn | input | 1 | Read strobe (the capture and release side effects happen on the clock edge) |
| busRdData | output | 8 | Read data, combinational from the address |
| count | output | 16 | Live count to the capture/compare channels |

## Verification
The assertions assume that a read and a write never arrive in the same cycle. They also assume that the address stays stable while a strobe is high. The stimulus therefore issues one access per cycle and drives all bus inputs only on the falling clock edge. The increment and restart properties rely on reset being held low for at least one edge before any access is made. The bench holds reset for several cycles before it starts any traffic.

// File: rtl/ctb_pkg.sv
package ctb_pkg;

  localparam logic [1:0] ADDR_LOW  = 2'd0;
  localparam logic [1:0] ADDR_HIGH = 2'd1;
  localparam logic [1:0] ADDR_SEL  = 2'd2;

  typedef enum logic [1:0] {
    SRC_LOW  = 2'd0,
    SRC_HIGH = 2'd1,
    SRC_ZERO = 2'd2
  } rdSrc_e;

  typedef struct packed {
    logic snapLow;
    logic releaseHigh;
    logic selWrite;
  } ctbStrobe_t;

endpackage

// File: rtl/ctb_ctrl.sv
module ctb_ctrl
  import ctb_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int SEL_W  = 2
) (
  input  logic [1:0]        busAddr,
  input  logic              busWrEn,
  input  logic [BYTE_W-1:0] busWrData,
  input  logic              busRdEn,
  output ctbStrobe_t        strb,
  output logic [SEL_W-1:0]  selData,
  output rdSrc_e            rdSrc
);

  logic unusedWrHi;
  assign unusedWrHi = ^busWrData[BYTE_W-1:SEL_W];

  always_comb begin
    strb.snapLow     = busRdEn && (busAddr == ADDR_LOW);
    strb.releaseHigh = busRdEn && (busAddr == ADDR_HIGH);
    strb.selWrite    = busWrEn && (busAddr == ADDR_SEL);
    selData          = busWrData[SEL_W-1:0];
    unique case (busAddr)
      ADDR_LOW:  rdSrc = SRC_LOW;
      ADDR_HIGH: rdSrc = SRC_HIGH;
      default:   rdSrc = SRC_ZERO;
    endcase
  end

endmodule

// File: rtl/ctb_datapath.sv
module ctb_datapath
  import ctb_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int SEL_W    = 2,
  parameter int DIV_STEP = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctbStrobe_t          strb,
  input  logic [SEL_W-1:0]    selData,
  input  rdSrc_e              rdSrc,
  output logic [CNT_W/2-1:0]  rdData,
  output logic [CNT_W-1:0]    count
);

  localparam int BYTE_W  = CNT_W / 2;
  localparam int NUM_SEL = 1 << SEL_W;
  localparam int DIV_W   = DIV_STEP * (NUM_SEL - 1);

  logic [SEL_W-1:0] sel;
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] limTab [NUM_SEL];
  logic [CNT_W-1:0] held;
  logic             locked;
  logic             tick;

  for (genvar g = 0; g < NUM_SEL; g++) begin : gen_lim
    assign limTab[g] = DIV_W'((64'd1 << (DIV_STEP * g)) - 64'd1);
  end

  assign tick = (divCnt == limTab[sel]);

  // Prescaler: restarts on a select write
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sel    <= '0;
      divCnt <= '0;
    end else if (strb.selWrite) begin
      sel    <= selData;
      divCnt <= '0;
    end else if (tick) begin
      divCnt <= '0;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  // Live counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
    end else if (tick && !strb.selWrite) begin
      count <= count + 1'b1;
    end
  end

  // Snapshot and lock
  always_ff @(posedge clk) begin
    if (!rstN) begin
      held   <= '0;
      locked <= 1'b0;
    end else if (strb.snapLow) begin
      held   <= count;
      locked <= 1'b1;
    end else if (strb.releaseHigh) begin
      locked <= 1'b0;
    end
  end

  always_comb begin
    unique case (rdSrc)
      SRC_LOW:  rdData = count[BYTE_W-1:0];
      SRC_HIGH: rdData = locked ? held[CNT_W-1:BYTE_W] : count[CNT_W-1:BYTE_W];
      default:  rdData = '0;
    endcase
  end

  // R2: undivided code steps every edge
  assert_step_every_cycle_R2: assert property (@(posedge clk) disable iff (!rstN)
    (sel == '0 && !strb.selWrite) |=> (count == $past(count) + 1'b1));

  // R4: no increment on the select-write edge
  assert_hold_on_select_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.selWrite |=> (count == $past(count)));

  // R8: the live count never jumps, locked or not
  assert_no_jump_R8: assert property (@(posedge clk) disable iff (!rstN)
    (count == $past(count)) || (count == $past(count) + 1'b1));

  // R6: a low read captures the count and locks
  assert_capture_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.snapLow |=> (locked && held == $past(count)));

  // R7: a high read clears the lock
  assert_release_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.releaseHigh && !strb.snapLow) |=> !locked);

endmodule

// File: rtl/cap_timebase.sv
module cap_timebase
  import ctb_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int SEL_W    = 2,
  parameter int DIV_STEP = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [1:0]          busAddr,
  input  logic                busWrEn,
  input  logic [CNT_W/2-1:0]  busWrData,
  input  logic                busRdEn,
  output logic [CNT_W/2-1:0]  busRdData,
  output logic [CNT_W-1:0]    count
);

  localparam int BYTE_W = CNT_W / 2;

  ctbStrobe_t       strb;
  logic [SEL_W-1:0] selData;
  rdSrc_e           rdSrc;

  ctb_ctrl #(.BYTE_W(BYTE_W), .SEL_W(SEL_W)) u_ctrl (
    .busAddr   (busAddr),
    .busWrEn   (busWrEn),
    .busWrData (busWrData),
    .busRdEn   (busRdEn),
    .strb      (strb),
    .selData   (selData),
    .rdSrc     (rdSrc)
  );

  ctb_datapath #(.CNT_W(CNT_W), .SEL_W(SEL_W), .DIV_STEP(DIV_STEP)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .selData (selData),
    .rdSrc   (rdSrc),
    .rdData  (busRdData),
    .count   (count)
  );

endmodule

// File: tb/cap_timebase_test.sv
module cap_timebase_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] busAddr = 2'd0;
  logic       busWrEn = 1'b0;
  logic [7:0] busWrData = 8'd0;
  logic       busRdEn = 1'b0;
  logic [7:0] busRdData;
  logic [15:0] count;

  int nChecks = 0;
  int nFails  = 0;
  bit started = 0;
  bit done    = 0;
  string curReq = "R1";

  // behavioural reference state
  int mCount = 0, mDiv = 0, mSel = 0, mHeld = 0;
  bit mLocked = 0;

  cap_timebase uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdEn(busRdEn), .busRdData(busRdData), .count(count)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (!rstN) begin
      mCount = 0; mDiv = 0; mSel = 0; mHeld = 0; mLocked = 0;
    end else begin
      bit selW;
      bit tick;
      selW = busWrEn && busAddr == 2'd2;
      tick = (mDiv == ((1 << (4 * mSel)) - 1));
      if (busRdEn && busAddr == 2'd0) begin
        mHeld = mCount; mLocked = 1;
      end else if (busRdEn && busAddr == 2'd1) begin
        mLocked = 0;
      end
      if (selW) begin
        mDiv = 0; mSel = busWrData & 3;
      end else if (tick) begin
        mDiv = 0; mCount = (mCount + 1) & 16'hFFFF;
      end else begin
        mDiv = mDiv + 1;
      end
    end
  end

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started) check(curReq, count, mCount);
  end

  function automatic int expRead(logic [1:0] a);
    case (a)
      2'd0:    return mCount & 255;
      2'd1:    return mLocked ? ((mHeld >> 8) & 255) : ((mCount >> 8) & 255);
      default: return 0;
    endcase
  endfunction

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      busRdEn = 0; busWrEn = 0;
    end
  endtask

  task automatic doRead(logic [1:0] a, string req);
    @(negedge clk);
    busWrEn = 0; busRdEn = 1; busAddr = a;
    #1 check(req, busRdData, expRead(a));
  endtask

  task automatic doWrite(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    busRdEn = 0; busWrEn = 1; busAddr = a; busWrData = d;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    busAddr = 2'd0; #1 check("R1", busRdData, 0);
    busAddr = 2'd1; #1 check("R1", busRdData, 0);
    check("R1", count, 0);
    @(negedge clk);
    rstN = 1; started = 1;
    curReq = "R2";
    idle(20);

    // R6/R7: capture near a byte boundary, then high read returns held byte
    curReq = "R8";
    while ((mCount & 255) != 250) idle(1);
    doRead(2'd0, "R6");
    idle(20);
    check("R6", mLocked, 1);
    doRead(2'd1, "R7");
    idle(3);
    // R10: unlocked high read returns live
    doRead(2'd1, "R10");
    idle(2);

    // R9: second low read replaces snapshot
    doRead(2'd0, "R6");
    idle(10);
    doRead(2'd0, "R9");
    idle(300);
    doRead(2'd1, "R9");
    idle(2);

    // R11: writes to count addresses ignored, select reads zero
    curReq = "R11";
    doWrite(2'd0, 8'hAA);
    doWrite(2'd1, 8'h55);
    doWrite(2'd3, 8'hFF);
    idle(5);
    doRead(2'd2, "R11");
    doRead(2'd3, "R11");
    idle(2);

    // R3/R4: divided rates and restart
    curReq = "R4"; doWrite(2'd2, 8'h01); curReq = "R3"; idle(100);
    curReq = "R4"; doWrite(2'd2, 8'h02); curReq = "R3"; idle(700);
    doRead(2'd0, "R6"); idle(400); doRead(2'd1, "R7");
    curReq = "R4"; doWrite(2'd2, 8'h03); curReq = "R3"; idle(2000);
    curReq = "R4"; doWrite(2'd2, 8'hFB); idle(4200);
    curReq = "R3"; idle(4200);

    // R5: wrap at full speed
    curReq = "R4"; doWrite(2'd2, 8'h00);
    curReq = "R2"; idle(10);
    while (mCount != 16'hFFF0) idle(1);
    curReq = "R5";
    idle(40);
    check("R5", (mCount < 16'h0030) ? 1 : 0, 1);
    doRead(2'd1, "R10");
    idle(4);

    finishRun();
  end

endmodule